// File: doc/BRIEF.md
# Shared Receive Character Queue

This block collects received characters from a group of serial channel receivers into one first-in, first-out store. Each stored entry holds the character, the number of the channel that produced it, and that channel's line error flags. A host read of the receive data word returns the oldest entry as a 16-bit status word whose top bit says whether the word holds data. The host removes that entry by asserting the pop strobe in the same cycle.

A second write path carries the diagnostic bytes that the self-test writes after a master reset. Diagnostic bytes are therefore already waiting for the host when it first reads. The not-empty output feeds the receive-data-available status bit and the interrupt request logic.

When the store is full, a push from a receiver is dropped. The loss is recorded against that channel and reported on the next entry that channel writes.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset the queue is empty: `not_empty` is 0 and `rd_word[15]` is 0.
- R2: The read word has this layout. Bit 15 is data valid. Bit 14 is overrun. Bit 13 is framing error. Bit 12 is parity error. Bits 11:8 hold the channel number, zero-extended. Bits 7:0 hold the character, with its LSB in bit 0.
- R3: Entries come out in the order they were accepted. Each pop removes exactly one entry. With `rd_pop` low, `rd_word` keeps showing the same entry.
- R4: `not_empty` is 1 exactly when at least one entry is stored.
- R5: A pop while the queue is empty returns a word with bit 15 = 0 and leaves the queue unchanged. A later push is read back correctly.
- R6: The queue holds `DEPTH` (default 256, a power of two) entries. A receiver push into a full queue, with no pop in the same cycle, is not stored.
- R7: A dropped receiver push marks its channel. The next entry that channel writes has bit 14 set, and the mark is then cleared. Other channels are not affected.
- R8: In one cycle, a push and a pop on a full queue are both carried out, and the queue stays full. A push and a pop on an empty queue store the pushed entry, and the pop returns bit 15 = 0.
- R9: A diagnostic push stores the byte with channel 0 and all error flags at 0. If a receiver pushes in the same cycle, the diagnostic push wins, and the receiver push is dropped and marked as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Receiver push strobe |
| wr_chan | input | 3 | Channel number of the pushed character |
| wr_char | input | 8 | Received character |
| wr_frame_err | input | 1 | Framing error for this character |
| wr_parity_err | input | 1 | Parity error for this character |
| wr_overrun | input | 1 | Receiver-side overrun for this character |
| diag_valid | input | 1 | Diagnostic byte push strobe |
| diag_byte | input | 8 | Diagnostic byte |
| rd_pop | input | 1 | Host read strobe; removes the head entry at the clock edge |
| rd_word | output | 16 | Head entry as a status word |
| not_empty | output | 1 | At least one entry stored |

## Verification
The bench pushes characters that vary the channel, the character value and each error flag. This separates the bit positions of the word layout and shows that ordering holds across channels. It runs the queue to full and then past full. This shows that drops are confined to the offending channel and that overrun marking is cleared once it has been reported. Single-cycle collisions are tried at both extremes: push with pop when full, push with pop when empty, and a diagnostic push against a receiver push. These show that the occupancy count survives each case and that the priority rule is applied.

// File: rtl/rx_status_fifo.sv
module rx_status_fifo #(
  parameter int DEPTH    = 256,
  parameter int CHANNELS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid,
  input  logic [$clog2(CHANNELS)-1:0] wr_chan,
  input  logic [7:0]                  wr_char,
  input  logic                        wr_frame_err,
  input  logic                        wr_parity_err,
  input  logic                        wr_overrun,
  input  logic                        diag_valid,
  input  logic [7:0]                  diag_byte,
  input  logic                        rd_pop,
  output logic [15:0]                 rd_word,
  output logic                        not_empty
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CH_W = $clog2(CHANNELS);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [14:0]         mem [DEPTH];
  logic [AW-1:0]       wr_ptr, rd_ptr;
  logic [AW:0]         count;
  logic [CHANNELS-1:0] ovr_pend;

  logic pop_ok, room, diag_ok, rx_ok, rx_drop, push_ok;
  logic [14:0] entry;

  assign pop_ok  = rd_pop && (count != '0);
  assign room    = (count != FULL_CNT) || pop_ok;
  assign diag_ok = diag_valid && room;
  assign rx_ok   = wr_valid && !diag_valid && room;
  assign rx_drop = wr_valid && !rx_ok;
  assign push_ok = diag_ok || rx_ok;

  assign entry = diag_valid
    ? {3'b000, 4'b0000, diag_byte}
    : {wr_overrun | ovr_pend[wr_chan], wr_frame_err, wr_parity_err,
       {(4-CH_W){1'b0}}, wr_chan, wr_char};

  assign not_empty = (count != '0);
  assign rd_word   = {not_empty, mem[rd_ptr]};

  always_ff @(posedge clk)
    if (push_ok) mem[wr_ptr] <= entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ovr_pend[c] <= 1'b0;
      else if (rx_drop && wr_chan == CH_W'(c))
        ovr_pend[c] <= 1'b1;
      else if (rx_ok && wr_chan == CH_W'(c))
        ovr_pend[c] <= 1'b0;
    end
  end
endmodule

module rx_status_fifo_chk #(
  parameter int DEPTH    = 256,
  parameter int CHANNELS = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_valid,
  input logic [$clog2(CHANNELS)-1:0] wr_chan,
  input logic                        diag_valid,
  input logic                        rd_pop,
  input logic                        not_empty,
  input logic [$clog2(DEPTH):0]      count,
  input logic [CHANNELS-1:0]         ovr_pend
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R5
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && rd_pop && !wr_valid && !diag_valid) |=> !not_empty);

  // R3
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (not_empty && rd_pop && !wr_valid && !diag_valid) |=> count == $past(count) - 1'b1);

  // R7
  full_drop_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT && wr_valid && !rd_pop && !diag_valid)
      |=> (count == FULL_CNT) && ovr_pend[$past(wr_chan)]);

  // R8
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT && rd_pop && wr_valid && !diag_valid) |=> count == FULL_CNT);

  // R8
  empty_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && rd_pop && wr_valid && !diag_valid) |=> count == 1);

  // R9
  diag_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_valid && wr_valid) |=> ovr_pend[$past(wr_chan)]);
endmodule

bind rx_status_fifo rx_status_fifo_chk #(.DEPTH(DEPTH), .CHANNELS(CHANNELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
  .diag_valid(diag_valid), .rd_pop(rd_pop), .not_empty(not_empty),
  .count(count), .ovr_pend(ovr_pend)
);

// File: tb/test_rx_status_fifo.sv
module test_rx_status_fifo;
  localparam int DEPTH = 256;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_frame_err = 0, wr_parity_err = 0, wr_overrun = 0;
  logic [2:0] wr_chan = 0;
  logic [7:0] wr_char = 0, diag_byte = 0;
  logic diag_valid = 0, rd_pop = 0;
  logic [15:0] rd_word;
  logic not_empty;

  rx_status_fifo i_rx_status_fifo (.*);

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  bit pend[8];

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: drives one cycle and updates the scoreboard queue; monitor compares pops.
  task automatic step(bit psh, int ch, int chr, bit f, bit p, bit o,
                      bit dg, int db, bit pp, string req);
    bit room;
    @(negedge clk);
    wr_valid = psh; wr_chan = 3'(ch); wr_char = 8'(chr);
    wr_frame_err = f; wr_parity_err = p; wr_overrun = o;
    diag_valid = dg; diag_byte = 8'(db); rd_pop = pp;
    #1;
    if (pp) begin
      if (exp_q.size() == 0)
        chk(rd_word[15] === 1'b0, req, rd_word, 16'h0000);
      else begin
        chk(rd_word === exp_q[0], req, rd_word, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
    room = exp_q.size() < DEPTH;
    if (dg && room) exp_q.push_back({1'b1, 7'd0, 8'(db)});
    if (psh) begin
      if (dg || !room) pend[ch] = 1;
      else begin
        exp_q.push_back({1'b1, o | pend[ch], f, p, 1'b0, 3'(ch), 8'(chr)});
        pend[ch] = 0;
      end
    end
    @(posedge clk); #1;
    wr_valid = 0; diag_valid = 0; rd_pop = 0;
  endtask

  task automatic push(int ch, int chr, bit f, bit p, bit o, string req);
    step(1, ch, chr, f, p, o, 0, 0, 0, req);
  endtask

  task automatic pop(string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, req);
  endtask

  task automatic check_ne(string req);
    @(negedge clk);
    chk(not_empty === (exp_q.size() > 0), req, {15'd0, not_empty}, {15'd0, exp_q.size() > 0});
  endtask

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(not_empty === 1'b0, "R1", {15'd0, not_empty}, 16'h0);
    chk(rd_word[15] === 1'b0, "R1", rd_word, 16'h0000);
    rst_n = 1;

    // R9: diagnostic bytes after reset
    step(0, 0, 0, 0, 0, 0, 1, 8'hA5, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 8'h3C, 0, "R9");
    check_ne("R4");
    pop("R9"); pop("R9");
    check_ne("R4");

    // R2, R3: flag and channel patterns
    push(1, 8'h41, 0, 0, 0, "R2");
    push(7, 8'hFE, 1, 0, 0, "R2");
    push(4, 8'h01, 0, 1, 0, "R2");
    push(2, 8'h80, 0, 0, 1, "R2");
    @(negedge clk); #1;
    chk(rd_word === exp_q[0], "R3", rd_word, exp_q[0]);
    @(negedge clk); #1;
    chk(rd_word === exp_q[0], "R3", rd_word, exp_q[0]);
    repeat (4) pop("R2");
    check_ne("R4");

    // R5: pop when empty, then push and read back
    pop("R5");
    check_ne("R5");
    push(3, 8'h5A, 0, 0, 0, "R5");
    check_ne("R4");
    pop("R5");

    // R6: fill to full, then an extra push on channel 5
    for (int i = 0; i < DEPTH; i++) push(i % 8 == 5 ? 6 : i % 8, i, 0, 0, 0, "R6");
    check_ne("R6");
    push(5, 8'hEE, 0, 0, 0, "R6");
    // R8: push and pop together when full
    step(1, 2, 8'h77, 0, 1, 0, 0, 0, 1, "R8");
    for (int i = 0; i < DEPTH; i++) pop("R6");
    check_ne("R6");
    pop("R5");

    // R7: overrun reported once on channel 5, not on channel 3
    push(5, 8'h11, 0, 0, 0, "R7");
    push(5, 8'h12, 0, 0, 0, "R7");
    push(3, 8'h13, 0, 0, 0, "R7");
    pop("R7"); pop("R7"); pop("R7");

    // R8: push and pop together when empty
    step(1, 6, 8'h99, 1, 0, 0, 0, 0, 1, "R8");
    check_ne("R8");
    pop("R8");

    // R9: diagnostic push collides with receiver push on channel 6
    step(1, 6, 8'h44, 0, 0, 0, 1, 8'hD1, 0, "R9");
    push(6, 8'h45, 0, 0, 0, "R9");
    pop("R9"); pop("R9");
    check_ne("R4");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule